// File: doc/BRIEF.md
# Three-Modulus Radix-4 Booth Residue Multiplier

This block multiplies two n-bit residues for one of three moduli picked by a 2-bit mode input: 2^n+1, 2^n or 2^n-1. One datapath serves all three. The multiplier operand is recoded into radix-4 Booth digits. The bit that wraps into the lowest digit depends on the modulus. Each digit selects the multiplicand or its double, scaled by a power of four. The scaling is a plain shift, a rotation or a rotation with the wrapped-in bits inverted, depending on the modulus. A negative digit takes the one's complement of its word. Every offset that these tricks leave behind is collected into one bias word, which is derived from the digit signs and magnitudes alone.

The partial products, the bias, one operand that only the 2^n+1 mode uses, and a zero pad are summed by a modulus-aware adder chain. In the 2^n+1 mode both operands and the result are in diminished-1 form, so the datapath computes X·Y + X + Y. In the 2^n-1 mode a value may carry either zero form (all zeros or all ones). The combinational result is captured in an output register whenever the input strobe is high. Parameter N (even, default 8) sets the operand width.

Top module: `mmb_mult`

## Requirements
- R1: The mode input selects the modulus as follows: 2'b00 selects 2^N+1, 2'b01 selects 2^N and 2'b10 selects 2^N-1. The code 2'b11 is illegal, and a strobed operation in that mode loads zero into z_out.
- R2: In mode 2'b01, z_out equals (x_in·y_in) mod 2^N, with both operands read as unsigned.
- R3: In mode 2'b10, z_out is congruent to x_in·y_in modulo 2^N-1. All-ones is accepted as an input zero, and the result may be returned in either zero form.
- R4: In mode 2'b00, x_in and y_in are diminished-1 codes of the values x_in+1 and y_in+1. z_out is the diminished-1 code of their product modulo 2^N+1, which is (x_in·y_in + x_in + y_in) mod (2^N+1), reported in its low N bits.
- R5: out_valid is high exactly one clock after a cycle with in_valid high, and z_out then holds that operation's result. While in_valid is low, out_valid is low and z_out keeps its value, whatever mode, x_in and y_in carry.
- R6: While rst_n is low, out_valid and z_out are zero.
- R7: Every Booth digit has at most one magnitude bit set (magnitude 1 or magnitude 2). Its sign bit is set only when a magnitude bit is set. There are N/2 digits, and the operation is correct for every multiplier pattern.
- R8: In mode 2'b00, a multiplicand of all ones (the value -1) returns the bitwise inverse of y_in.
- R9: Multiplier operands with the top bit set give the correct result in every mode. This exercises the wrap bit, which is the inverse of the top bit for 2^N+1, zero for 2^N, and the top bit for 2^N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | Modulus select: 00 for 2^N+1, 01 for 2^N, 10 for 2^N-1, 11 illegal |
| x_in | input | N | Multiplicand residue |
| y_in | input | N | Multiplier residue, Booth recoded |
| out_valid | output | 1 | z_out was updated at the last clock edge |
| z_out | output | N | Registered modular product |

## Verification
The assertions check properties that hold on every clock. They cover the strobe-to-valid timing and the holding of z_out between strobes. They cover the zero result in the illegal mode and the one-hot shape of every Booth digit. They also cover three identity cases that need no arithmetic model: multiplying by one in the 2^N mode, a zero multiplicand in the 2^N-1 mode, and the all-ones multiplicand in the 2^N+1 mode.

Only the bench scenarios can show that general products are right in each mode. They rely on the bench's own model, which converts out of and back into diminished-1 form for the 2^N+1 mode, and on a full sweep of every multiplier pattern. The same goes for the reset state, the corner operands with the top bit set, and the fact that the mode, x_in and y_in have no effect while in_valid is low.

// File: rtl/mmb_pkg.sv
package mmb_pkg;

  // Modulus selection, encoded as seen on the mode input.
  typedef enum logic [1:0] {
    MOD_PLUS  = 2'b00,  // 2^N+1, diminished-1 operands
    MOD_POW   = 2'b01,  // 2^N
    MOD_MINUS = 2'b10,  // 2^N-1, two zero forms
    MOD_BAD   = 2'b11   // illegal
  } mod_sel_e;

  // One radix-4 Booth digit: sign plus one-hot magnitude.
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdigit_t;

endpackage

// File: rtl/mmb_booth_enc.sv
module mmb_booth_enc
  import mmb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]           y,
  input  mod_sel_e               sel,
  output logic                   wrap,
  output bdigit_t [N/2-1:0]      dig
);
  localparam int ND = N / 2;

  // Bit fed into the low end of digit 0; it cancels or reuses the
  // weight 2^N carried by the top multiplier bit.
  always_comb begin
    case (sel)
      MOD_PLUS:  wrap = ~y[N-1];
      MOD_MINUS: wrap = y[N-1];
      default:   wrap = 1'b0;
    endcase
  end

  logic [N:0] y_ext;
  assign y_ext = {y, wrap};

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic hi, mid, lo;
    assign hi  = y_ext[2*i+2];
    assign mid = y_ext[2*i+1];
    assign lo  = y_ext[2*i];
    assign dig[i].one = mid ^ lo;
    assign dig[i].two = (hi & ~mid & ~lo) | (~hi & mid & lo);
    assign dig[i].neg = hi & ~(mid & lo);
  end

endmodule

// File: rtl/mmb_ppgen.sv
module mmb_ppgen
  import mmb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]            x,
  input  mod_sel_e                sel,
  input  bdigit_t [N/2-1:0]       dig,
  output logic [N/2-1:0][N-1:0]   pp
);
  localparam int ND = N / 2;

  // x * 2^j in the selected modulus: zero fill, rotate, or rotate with
  // the wrapped-in bits inverted (leaves an offset of 2^j-1 for 2^N+1).
  function automatic logic [N-1:0] scale2(logic [N-1:0] v, int j, mod_sel_e s);
    logic [N-1:0] r;
    for (int b = 0; b < N; b++) begin
      if (b >= j) r[b] = v[b-j];
      else begin
        case (s)
          MOD_MINUS: r[b] = v[N-j+b];
          MOD_PLUS:  r[b] = ~v[N-j+b];
          default:   r[b] = 1'b0;
        endcase
      end
    end
    return r;
  endfunction

  for (genvar i = 0; i < ND; i++) begin : g_pp
    logic [N-1:0] by_one, by_two, mag;
    assign by_one = scale2(x, 2*i, sel);
    assign by_two = scale2(x, 2*i+1, sel);
    assign mag    = dig[i].two ? by_two : (dig[i].one ? by_one : '0);
    assign pp[i]  = dig[i].neg ? ~mag : mag;
  end

endmodule

// File: rtl/mmb_accum.sv
module mmb_accum
  import mmb_pkg::*;
#(
  parameter int N = 8,
  parameter int K = 7
) (
  input  logic [K-1:0][N:0] ops,
  input  mod_sel_e          sel,
  output logic [N:0]        sum
);
  localparam logic [N+1:0] MPLUS = {2'b01, {N{1'b0}}} | {{(N+1){1'b0}}, 1'b1};

  // Two-operand modular add: carry dropped, end-around carry, or a
  // single conditional subtract of 2^N+1 on N+1-bit residues.
  function automatic logic [N:0] madd(logic [N:0] a, logic [N:0] b, mod_sel_e s);
    logic [N+1:0] t;
    t = {1'b0, a} + {1'b0, b};
    case (s)
      MOD_POW:   madd = {1'b0, t[N-1:0]};
      MOD_MINUS: madd = {1'b0, t[N-1:0]} + {{N{1'b0}}, t[N]};
      default:   madd = (t >= MPLUS) ? (t[N:0] - MPLUS[N:0]) : t[N:0];
    endcase
  endfunction

  logic [N:0] acc;
  always_comb begin
    acc = '0;
    for (int k = 0; k < K; k++) acc = madd(acc, ops[k], sel);
  end
  assign sum = acc;

endmodule

// File: rtl/mmb_bias.sv
module mmb_bias
  import mmb_pkg::*;
#(
  parameter int N = 8
) (
  input  bdigit_t [N/2-1:0] dig,
  input  mod_sel_e          sel,
  output logic [N:0]        bias
);
  localparam int ND = N / 2;
  localparam logic [N:0] MP  = {1'b1, {(N-1){1'b0}}, 1'b1};
  localparam logic [N:0] ONE = {{N{1'b0}}, 1'b1};
  localparam logic [N:0] TWO = {{(N-1){1'b0}}, 2'b10};

  logic [ND-1:0][N:0] term;

  for (genvar i = 0; i < ND; i++) begin : g_term
    localparam logic [N:0] E_ONE = (N+1)'((1 << (2*i)) - 1);
    localparam logic [N:0] E_TWO = (N+1)'((1 << (2*i+1)) - 1);
    logic [N:0] e, t;
    assign e = dig[i].two ? E_TWO : E_ONE;
    // Cancels the complement offset (-1 or -2) and the inverted-rotation
    // offset (2^j-1) that this digit's word carries.
    always_comb begin
      t = '0;
      if (dig[i].one | dig[i].two) begin
        case (sel)
          MOD_POW:  t = dig[i].neg ? ONE : '0;
          MOD_PLUS: t = dig[i].neg ? (e + TWO) : ((e == '0) ? '0 : (MP - e));
          default:  t = '0;
        endcase
      end
    end
    assign term[i] = t;
  end

  mmb_accum #(.N(N), .K(ND)) u_bsum (
    .ops (term),
    .sel (sel),
    .sum (bias)
  );

endmodule

// File: rtl/mmb_mult.sv
module mmb_mult
  import mmb_pkg::*;
#(
  parameter int N = 8  // operand width, must be even
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   mode,
  input  logic [N-1:0] x_in,
  input  logic [N-1:0] y_in,
  output logic         out_valid,
  output logic [N-1:0] z_out
);
  localparam int ND   = N / 2;
  localparam int NOPS = ND + 3;

  mod_sel_e              sel;
  logic                  wrap_bit;
  bdigit_t [ND-1:0]      digits;
  logic [ND-1:0][N-1:0]  pps;
  logic [N:0]            bias_word;
  logic [NOPS-1:0][N:0]  ops;
  logic [N:0]            mod_sum;
  logic                  mode_bad;
  logic [N-1:0]          z_next;

  assign sel      = mod_sel_e'(mode);
  assign mode_bad = (sel == MOD_BAD);

  mmb_booth_enc #(.N(N)) u_enc (
    .y    (y_in),
    .sel  (sel),
    .wrap (wrap_bit),
    .dig  (digits)
  );

  mmb_ppgen #(.N(N)) u_pp (
    .x   (x_in),
    .sel (sel),
    .dig (digits),
    .pp  (pps)
  );

  mmb_bias #(.N(N)) u_bias (
    .dig  (digits),
    .sel  (sel),
    .bias (bias_word)
  );

  // Operand list: N/2 partial products, bias, the +Y term used only for
  // diminished-1 operation, and a zero pad.
  always_comb begin
    for (int i = 0; i < ND; i++) ops[i] = {1'b0, pps[i]};
    ops[ND]   = bias_word;
    ops[ND+1] = (sel == MOD_PLUS) ? {1'b0, y_in} : '0;
    ops[ND+2] = '0;
  end

  mmb_accum #(.N(N), .K(NOPS)) u_sum (
    .ops (ops),
    .sel (sel),
    .sum (mod_sum)
  );

  assign z_next = mode_bad ? '0 : mod_sum[N-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      z_out     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) z_out <= z_next;
    end
  end

endmodule

// File: rtl/mmb_mult_chk.sv
module mmb_mult_chk
  import mmb_pkg::*;
#(
  parameter int N = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        mode,
  input logic [N-1:0]      x_in,
  input logic [N-1:0]      y_in,
  input logic              out_valid,
  input logic [N-1:0]      z_out,
  input bdigit_t [N/2-1:0] digits
);
  localparam logic [N-1:0] ONE_W = {{(N-1){1'b0}}, 1'b1};

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(z_out)));

  assert_illegal_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11) |=> (z_out == '0));

  assert_unit_pow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b01 && x_in == ONE_W) |=> (z_out == $past(y_in)));

  assert_zero_minus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10 && x_in == '0) |=> (z_out == '0 || z_out == '1));

  assert_neg_one_plus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00 && x_in == '1) |=> (z_out == ~$past(y_in)));

  for (genvar i = 0; i < N/2; i++) begin : g_dchk
    assert_digit_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({digits[i].one, digits[i].two}));
    assert_digit_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
      digits[i].neg |-> (digits[i].one || digits[i].two));
  end

endmodule

bind mmb_mult mmb_mult_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mode      (mode),
  .x_in      (x_in),
  .y_in      (y_in),
  .out_valid (out_valid),
  .z_out     (z_out),
  .digits    (digits)
);

// File: tb/tb_mmb_mult.sv
`timescale 1ns/1ps
module tb_mmb_mult;
  localparam int N    = 8;
  localparam int MASK = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   mode;
  logic [N-1:0] x_in, y_in;
  logic         out_valid;
  logic [N-1:0] z_out;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mmb_mult #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .x_in(x_in), .y_in(y_in), .out_valid(out_valid), .z_out(z_out)
  );

  // Behavioural model: plain integer arithmetic per modulus.
  function automatic longint model(int md, int a, int b);
    longint m, p;
    case (md)
      0: begin
        m = longint'(MASK) + 2;
        p = (longint'(a + 1) * longint'(b + 1)) % m;
        return ((p + m - 1) % m) & MASK;
      end
      1: return (longint'(a) * longint'(b)) & MASK;
      2: begin
        m = MASK;
        return ((longint'(a) % m) * (longint'(b) % m)) % m;
      end
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // One strobed operation, then one idle cycle with junk inputs.
  task automatic run(int md, int a, int b, string tag);
    logic [N-1:0] held;
    longint got;
    @(negedge clk);
    in_valid = 1'b1; mode = md[1:0]; x_in = a[N-1:0]; y_in = b[N-1:0];
    @(negedge clk);
    in_valid = 1'b0; mode = 2'($urandom); x_in = N'($urandom); y_in = N'($urandom);
    check({tag, " R5 valid"}, longint'(out_valid), 1);
    got = (md == 2) ? longint'(z_out) % MASK : longint'(z_out);
    check(tag, got, model(md, a, b));
    held = z_out;
    @(negedge clk);
    check("R5 idle valid", longint'(out_valid), 0);
    check("R5 idle hold", longint'(z_out), longint'(held));
  endtask

  function automatic string mtag(int md);
    return (md == 0) ? "R4" : (md == 1) ? "R2" : "R3";
  endfunction

  initial begin
    int corner[6];
    corner = '{0, 1, MASK, MASK - 1, 1 << (N - 1), 'h55 & MASK};
    rst_n = 1'b0; in_valid = 1'b0; mode = 2'b00; x_in = '0; y_in = '0;
    repeat (3) @(negedge clk);
    check("R6 reset valid", longint'(out_valid), 0);
    check("R6 reset z", longint'(z_out), 0);
    rst_n = 1'b1;

    // Corner operands per mode; those with the top bit set cover R9.
    for (int md = 0; md < 3; md++)
      foreach (corner[i])
        foreach (corner[j])
          run(md, corner[i], corner[j],
              (corner[j] >> (N - 1)) != 0 ? {mtag(md), " R9"} : mtag(md));

    // R8: all-ones multiplicand in the 2^N+1 mode.
    for (int v = 0; v < 16; v++) run(0, MASK, (v * 37) & MASK, "R8");

    // R7: every multiplier pattern, each mode.
    for (int md = 0; md < 3; md++)
      for (int v = 0; v <= MASK; v++) run(md, 'h6b & MASK, v, {"R7 ", mtag(md)});

    // Random operands per mode.
    for (int md = 0; md < 3; md++)
      for (int k = 0; k < 200; k++)
        run(md, int'($urandom) & MASK, int'($urandom) & MASK, mtag(md));

    // R1: illegal mode forces zero.
    for (int k = 0; k < 20; k++)
      run(3, int'($urandom) & MASK, int'($urandom) & MASK, "R1");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule